// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies a DIM x K matrix A by a K x DIM matrix B on a square DIM x DIM grid of multiply-accumulate cells. Each cell owns one element C[m][n] of the result and keeps its running sum locally for the whole K dimension. Partial sums never move between cells. One column of A (A[0..DIM-1][k]) and one row of B (B[k][0..DIM-1]) are presented per clock at the block's edge. The block delays row m of A by m cycles and column n of B by n cycles, so the two operands of each product meet in cell (m,n) at cycle k+m+n. A operands then move one cell right per clock and B operands one cell down per clock.

A clear pulse zeroes every accumulator before a new tile. After the last operand pair, a start pulse begins the readout. The block waits until the farthest cell has finished, copies all sums into a shift chain at once, and shifts them out one word per clock in row-major order. A done pulse follows the last word. Operands for the next tile may enter once the copy into the chain has been made.

Top module: `os_matmul_grid`

## Requirements
- R1: Each drained word equals the signed sum over all accepted steps k of A[m][k]*B[k][n], with 8-bit two's complement operands and a two's complement result of AW = 16 + ceil(log2 KMAX) bits. A step is a cycle with both a_vld and b_vld high. Column m of a_col is bits [m*8 +: 8] and row n of b_row is bits [n*8 +: 8].
- R2: A drain emits exactly DIM*DIM words on consecutive cycles with out_vld high, in row-major order: C[0][0], C[0][1], ..., C[DIM-1][DIM-1].
- R3: A start pulse accepted in cycle s gives the first valid word in cycle s+2*DIM. start must come at least one cycle after the last step.
- R4: done is high for exactly one cycle, the cycle right after the last word, and out_vld is low in that cycle.
- R5: A clr pulse with no step in the same cycle sets every accumulator to zero, so a later drain reports only the steps made after it.
- R6: Without clr, the steps of successive feeds keep adding into the same sums, even across a drain.
- R7: A cycle with only one of a_vld and b_vld high adds nothing to any sum.
- R8: start is ignored from the cycle after an accepted start up to and including the done cycle. It adds no words and does not shift the timing of the drain in progress.
- R9: After reset, out_vld and done are low and all sums are zero.
- R10: KMAX steps of the most negative operands (-128 * -128) give 262144 without wrap-around for KMAX=16.
- R11: Idle cycles between steps of a tile do not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Zero all accumulators |
| a_vld | input | 1 | a_col holds a valid A column |
| a_col | input | DIM*8 | A[m][k] for every row m, row m at bits m*8 |
| b_vld | input | 1 | b_row holds a valid B row |
| b_row | input | DIM*8 | B[k][n] for every column n, column n at bits n*8 |
| start | input | 1 | Begin the readout of the finished sums |
| out_vld | output | 1 | out_data holds a result word |
| out_data | output | AW | Result word, signed |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
A cell that skips a product, adds one twice, or pairs an operand with a neighbour's operand from the wrong step shows up as a wrong value at a fixed position in the row-major drain, so the position of the mismatch points to the faulty cell. A skew or forwarding stage off by one cycle corrupts every cell downstream of it. A wrong flush count or drain counter moves out_vld or done by whole cycles, and a per-cycle comparison catches that in the first cycle of the drain. Stale sums left after clr, or sums lost without clr, appear in the next drain after the tile that follows.

// File: rtl/os_matmul_grid.sv
module os_matmul_grid #(
  parameter int DIM  = 4,
  parameter int DW   = 8,
  parameter int KMAX = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic                             a_vld,
  input  logic [DIM*DW-1:0]                a_col,
  input  logic                             b_vld,
  input  logic [DIM*DW-1:0]                b_row,
  input  logic                             start,
  output logic                             out_vld,
  output logic [2*DW+$clog2(KMAX)-1:0]     out_data,
  output logic                             done
);
  localparam int AW    = 2*DW + $clog2(KMAX);
  localparam int PW    = 2*DW;
  localparam int WORDS = DIM*DIM;
  localparam int FLUSH = 2*(DIM-1);
  localparam int CW    = $clog2(WORDS + FLUSH + 1);

  typedef logic [DW:0] opnd_t;
  typedef enum logic [1:0] {S_IDLE, S_FLUSH, S_DRAIN, S_FIN} st_t;

  opnd_t a_edge [DIM];
  opnd_t b_edge [DIM];
  opnd_t ah [DIM][DIM-1];
  opnd_t bv [DIM-1][DIM];
  logic signed [AW-1:0] acc [DIM][DIM];
  logic signed [AW-1:0] chain [WORDS];
  st_t state;
  logic [CW-1:0] cnt;

  genvar m, n, j;
  generate
    for (m = 0; m < DIM; m++) begin : g_skew
      opnd_t ad [m+1];
      opnd_t bd [m+1];
      assign ad[0] = {a_vld, a_col[m*DW +: DW]};
      assign bd[0] = {b_vld, b_row[m*DW +: DW]};
      for (j = 1; j <= m; j++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin
            ad[j] <= '0;
            bd[j] <= '0;
          end else begin
            ad[j] <= ad[j-1];
            bd[j] <= bd[j-1];
          end
      end
      assign a_edge[m] = ad[m];
      assign b_edge[m] = bd[m];
    end

    for (m = 0; m < DIM; m++) begin : g_row
      for (n = 0; n < DIM; n++) begin : g_col
        opnd_t ai, bi;
        logic signed [PW-1:0] prod;
        logic signed [AW-1:0] sum_q;

        if (n == 0) begin : g_al
          assign ai = a_edge[m];
        end else begin : g_an
          assign ai = ah[m][n-1];
        end
        if (m == 0) begin : g_bt
          assign bi = b_edge[n];
        end else begin : g_bn
          assign bi = bv[m-1][n];
        end

        assign prod = $signed(ai[DW-1:0]) * $signed(bi[DW-1:0]);

        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)                  sum_q <= '0;
          else if (clr)                sum_q <= '0;
          else if (ai[DW] && bi[DW])   sum_q <= sum_q + {{(AW-PW){prod[PW-1]}}, prod};
        assign acc[m][n] = sum_q;

        if (n < DIM-1) begin : g_fwd_a
          opnd_t aq;
          always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) aq <= '0;
            else        aq <= ai;
          assign ah[m][n] = aq;
        end
        if (m < DIM-1) begin : g_fwd_b
          opnd_t bq;
          always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) bq <= '0;
            else        bq <= bi;
          assign bv[m][n] = bq;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE:  if (start) begin
                   state <= S_FLUSH;
                   cnt   <= CW'(FLUSH);
                 end
        S_FLUSH: if (cnt == '0) state <= S_DRAIN;
                 else           cnt   <= cnt - 1'b1;
        S_DRAIN: if (cnt == CW'(WORDS-1)) state <= S_FIN;
                 else                     cnt   <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) chain[i] <= '0;
    end else if (state == S_FLUSH && cnt == '0) begin
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++)
          chain[r*DIM+c] <= acc[r][c];
    end else if (state == S_DRAIN) begin
      for (int i = 0; i < WORDS-1; i++) chain[i] <= chain[i+1];
      chain[WORDS-1] <= '0;
    end

  assign out_vld  = (state == S_DRAIN);
  assign done     = (state == S_FIN);
  assign out_data = chain[0];

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_vld) |-> done);
  p_drain_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !$past(out_vld)) |=> out_vld);
  p_restart_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && start) |=> (out_vld || done));
  p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc[0][0] == '0 && acc[DIM-1][DIM-1] == '0));
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_vld && done));
endmodule

// File: tb/os_matmul_grid_test.sv
`timescale 1ns/1ps
module os_matmul_grid_test;
  localparam int DIM = 4, DW = 8, KMAX = 16;
  localparam int AW = 2*DW + $clog2(KMAX);
  localparam int WORDS = DIM*DIM;

  logic clk = 0, rst_n = 0, clr = 0, a_vld = 0, b_vld = 0, start = 0;
  logic [DIM*DW-1:0] a_col = '0, b_row = '0;
  logic out_vld, done;
  logic [AW-1:0] out_data;

  os_matmul_grid #(.DIM(DIM), .DW(DW), .KMAX(KMAX)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .a_vld(a_vld), .a_col(a_col),
    .b_vld(b_vld), .b_row(b_row), .start(start), .out_vld(out_vld),
    .out_data(out_data), .done(done));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint refc [DIM][DIM];
  longint snap [WORDS];
  int first = -1000, last_done = -1;
  int checks = 0, errors = 0;
  bit finished = 0;
  string scen = "R9";
  int av [DIM], bw [DIM];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    bit ev, ed;
    ev = (cyc >= first) && (cyc < first + WORDS);
    ed = (cyc == first + WORDS);
    check(out_vld == ev, "R3", "out_vld", out_vld, ev);
    check(done == ed, "R4", "done", done, ed);
    if (ev && out_vld)
      check($signed(out_data) == snap[cyc-first], {"R1 R2 ", scen}, "word",
            $signed(out_data), snap[cyc-first]);
  end

  task automatic drive(bit a_on, bit b_on, bit cl, bit st);
    @(negedge clk);
    a_vld = a_on; b_vld = b_on; clr = cl; start = st;
    for (int m = 0; m < DIM; m++) begin
      a_col[m*DW +: DW] = av[m][DW-1:0];
      b_row[m*DW +: DW] = bw[m][DW-1:0];
    end
    if (cl) begin
      for (int m = 0; m < DIM; m++) for (int n = 0; n < DIM; n++) refc[m][n] = 0;
    end else if (a_on && b_on) begin
      for (int m = 0; m < DIM; m++) for (int n = 0; n < DIM; n++)
        refc[m][n] += longint'(av[m]) * longint'(bw[n]);
    end
    if (st && cyc > last_done) begin
      first = cyc + 2*DIM;
      last_done = first + WORDS;
      for (int m = 0; m < DIM; m++) for (int n = 0; n < DIM; n++) snap[m*DIM+n] = refc[m][n];
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) drive(0, 0, 0, 0);
  endtask

  task automatic rand_ops();
    for (int m = 0; m < DIM; m++) begin
      av[m] = int'($urandom_range(0, 255)) - 128;
      bw[m] = int'($urandom_range(0, 255)) - 128;
    end
  endtask

  task automatic drain();
    drive(0, 0, 0, 1);
    idle(2*DIM + WORDS + 2);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < DIM; m++) begin av[m] = 0; bw[m] = 0; end
    for (int m = 0; m < DIM; m++) for (int n = 0; n < DIM; n++) refc[m][n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state at the ports, then a drain of zeros
    check(out_vld == 0, "R9", "out_vld after reset", out_vld, 0);
    check(done == 0, "R9", "done after reset", done, 0);
    scen = "R9";
    drain();

    // R1: random tile, K = 4
    scen = "R1";
    drive(0, 0, 1, 0);
    for (int k = 0; k < 4; k++) begin rand_ops(); drive(1, 1, 0, 0); end
    drain();

    // R10: KMAX steps of extreme operands
    scen = "R10";
    drive(0, 0, 1, 0);
    for (int k = 0; k < KMAX; k++) begin
      for (int m = 0; m < DIM; m++) begin av[m] = -128; bw[m] = (m == 1) ? 127 : -128; end
      drive(1, 1, 0, 0);
    end
    drain();
    check(snap[0] == 262144, "R10", "reference extreme sum", snap[0], 262144);

    // R6: no clr, sums keep adding
    scen = "R6";
    for (int k = 0; k < 3; k++) begin rand_ops(); drive(1, 1, 0, 0); end
    drain();

    // R7 and R11: one-sided valids and gaps inside a tile
    scen = "R7 R11";
    drive(0, 0, 1, 0);
    for (int k = 0; k < 6; k++) begin
      rand_ops(); drive(1, 1, 0, 0);
      rand_ops(); drive(1, 0, 0, 0);
      rand_ops(); drive(0, 1, 0, 0);
      idle(k % 3);
    end
    drain();

    // R8: start during drain and in the done cycle is ignored
    scen = "R8";
    drive(0, 0, 1, 0);
    for (int k = 0; k < 5; k++) begin rand_ops(); drive(1, 1, 0, 0); end
    drive(0, 0, 0, 1);
    idle(2*DIM + 2);
    drive(0, 0, 0, 1);
    begin
      int r;
      r = last_done - cyc - 1;
      for (int i = 0; i < r; i++) drive(0, 0, 0, 0);
    end
    drive(0, 0, 0, 1);
    check(first + WORDS == cyc, "R8", "start landed in done cycle", cyc, first + WORDS);
    drive(0, 0, 0, 1);
    idle(2*DIM + WORDS + 2);

    // R5: clr alone gives zeros
    scen = "R5";
    drive(0, 0, 1, 0);
    drain();

    idle(2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule